// File: doc/BRIEF.md
# Multi-Level Vectored Interrupt Controller

This controller gathers seventeen interrupt request lines into seven priority levels and offers one winner at a time to a CPU core. A level can be wired in three ways. It can carry a single source on its own vector. It can fan out to several vectors, one per source. Or it can hold several sources that share one vector. Which level wins is set by a software-written priority code. Inside a level the winner is fixed by hardware: the lowest vector address wins.

When the CPU accepts the request, the controller sets a global interrupt disable and pulses a request to save the program counter and flags. It then reads two bytes from vector memory, high byte first, and builds the 16-bit start address of the service routine. The disable stays set until the CPU signals return-from-interrupt.

Software uses one write port to program three things: the priority code, the level enables and the write-one-to-clear pending flags.

Top module: `irqc_top`

## Requirements
- R1: A source's pending flag is set on the clock after its request goes from low to high. A request held high does not set the flag again after it has been cleared.
- R2: A write with `wr_sel`=2 clears every pending flag whose data bit is one. Flags under zero data bits keep their value.
- R3: Level enables are written with `wr_sel`=1, bit n for level n, and all are one after reset. A disabled level never raises `irq_req`, even while its sources are pending.
- R4: The priority code is written with `wr_sel`=0, data bits 7:0. For a code e from 0 to 6, level e ranks highest, then e+1 and so on upward, wrapping from 6 back to 0. Code 7 ranks level 6 highest, descending to level 0. Every other code ranks level 0 highest, ascending.
- R5: Within a level the pending source with the lowest vector address wins. Sources 0 to 12 use vector 0xC0+2·n. Sources 13 to 16 all share vector 0xDA.
- R6: Sources map to levels as follows: 0 to L0; 1 and 2 to L1; 3, 4 and 5 to L2; 6 and 7 to L3; 8 and 9 to L4; 10, 11 and 12 to L5; 13 to 16 to L6. `irq_level` and `irq_vector` show the winner while `irq_req` is high.
- R7: If `irq_ack` is high on a clock edge where `irq_req` is high, the grant happens. `gdis` is then high from the next cycle, and `push_ctx` is high for exactly that one cycle.
- R8: After a grant, `fetch_busy` is high for two cycles. `vec_rd_addr` shows the vector in the first cycle and the vector plus one in the second. In the cycle after that, `isr_valid` rises and `isr_addr` holds {byte at vector, byte at vector+1}.
- R9: `gdis` stays high and `irq_req` stays low until `reti` is seen while `isr_valid` is high. A `reti` during the fetch is ignored.
- R10: A grant clears the pending flag of the winning source if that source owns its vector. Pending flags of the shared-vector sources stay set.
- R11: After reset all pending flags are zero, the priority code is zero, and `irq_req`, `gdis`, `push_ctx`, `fetch_busy` and `isr_valid` are low.
- R12: `irq_ack` while `irq_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 17 | Interrupt request lines, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 priority code, 1 level enables, 2 pending clear |
| wr_data | input | 17 | Write data |
| irq_ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | CPU return-from-interrupt strobe |
| vec_rd_data | input | 8 | Vector memory byte at `vec_rd_addr`, same cycle |
| irq_req | output | 1 | Request presented to the CPU |
| irq_level | output | 3 | Winning level |
| irq_vector | output | 8 | Winning vector address |
| gdis | output | 1 | Global interrupt disable |
| push_ctx | output | 1 | One-cycle request to save PC and flags |
| vec_rd_addr | output | 8 | Vector memory read address |
| fetch_busy | output | 1 | Vector fetch in progress |
| isr_addr | output | 16 | Assembled service routine address |
| isr_valid | output | 1 | `isr_addr` is valid, routine in service |
| pend | output | 17 | Pending flags |

## Verification
The assertions assume the CPU raises `irq_ack` only for single cycles. They also assume `reti` comes only from a routine in service, and that `vec_rd_data` is the combinational contents of vector memory at `vec_rd_addr`. The bench drives `irq_ack` and `reti` as one-cycle pulses placed by the test sequence, and it models vector memory as a fixed function of the address. A `reti` is deliberately placed inside the fetch window, and an `irq_ack` is sent with no request present. This tests that both are ignored without breaking the assumptions the properties rely on.

// File: rtl/irqc_pkg.sv
// Shared constants, state encoding and mapping functions for the
// interrupt controller. Assumes the default 17-source, 7-level layout.
package irqc_pkg;
    localparam int IRQC_NUM_SRC  = 17;
    localparam int IRQC_NUM_LVL  = 7;
    localparam int IRQC_NUM_OWN  = 13;
    localparam logic [7:0] IRQC_VEC_BASE = 8'hC0;

    typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO, ST_SERVE} irqc_state_t;

    // Level that a source belongs to.
    function automatic int src_level(input int s);
        if (s == 0)       return 0;
        else if (s <= 2)  return 1;
        else if (s <= 5)  return 2;
        else if (s <= 7)  return 3;
        else if (s <= 9)  return 4;
        else if (s <= 12) return 5;
        else              return 6;
    endfunction

    // Rank of a level under a priority code; 0 is served first.
    function automatic int lvl_rank(input int l, input logic [7:0] code, input int nl);
        int c;
        c = int'(code);
        if (c < nl)       return (l - c + nl) % nl;
        else if (c == nl) return nl - 1 - l;
        else              return l;
    endfunction
endpackage

// File: rtl/irqc_pending.sv
// Pending flag bank: sets a flag on a rising request edge and clears
// it on a clear mask. Assumes src_req is synchronous to clk.
module irqc_pending #(
    parameter int N = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_req,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    // Track previous request level and update pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= src_req;
            pend  <= (pend & ~clr_mask) | (src_req & ~req_q);
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Two-stage arbiter: picks the lowest source per level, then the best
// ranked enabled level. Purely combinational.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 17,
    parameter int NUM_LVL = 7,
    parameter int NUM_OWN = 13,
    parameter int PRIO_W  = 8,
    parameter int VEC_W   = 8,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_LVL-1:0] lvl_en,
    input  logic [PRIO_W-1:0]  prio,
    output logic               any,
    output logic [LVL_W-1:0]   win_lvl,
    output logic [SRC_W-1:0]   win_src,
    output logic [VEC_W-1:0]   win_vec
);
    logic [NUM_LVL-1:0] lvl_hit;
    logic [SRC_W-1:0]   lvl_src [NUM_LVL];

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        // Lowest-index pending source inside this level.
        always_comb begin
            lvl_hit[l] = 1'b0;
            lvl_src[l] = '0;
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (src_level(s) == l && pend[s]) begin
                    lvl_hit[l] = lvl_en[l];
                    lvl_src[l] = SRC_W'(s);
                end
            end
        end
    end

    // Pick the enabled level with the smallest rank.
    always_comb begin
        int best;
        best    = NUM_LVL;
        any     = 1'b0;
        win_lvl = '0;
        win_src = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_hit[l] && lvl_rank(l, 8'(prio), NUM_LVL) < best) begin
                best    = lvl_rank(l, 8'(prio), NUM_LVL);
                any     = 1'b1;
                win_lvl = LVL_W'(l);
                win_src = lvl_src[l];
            end
        end
    end

    // Vector address: owned sources get their own slot, the rest share one.
    always_comb begin
        if (int'(win_src) < NUM_OWN)
            win_vec = VEC_W'(IRQC_VEC_BASE) + VEC_W'(2 * int'(win_src));
        else
            win_vec = VEC_W'(IRQC_VEC_BASE) + VEC_W'(2 * NUM_OWN);
    end
endmodule

// File: rtl/irqc_fetch.sv
// Grant and vector fetch sequencer: on a CPU acknowledge it saves the
// vector, raises global disable, pulses the context push, reads two
// bytes and holds the routine address until return-from-interrupt.
// Assumes vector memory answers in the same cycle.
module irqc_fetch
    import irqc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             avail,
    input  logic             irq_ack,
    input  logic             reti,
    input  logic [VEC_W-1:0] vec_in,
    input  logic [7:0]       rd_data,
    output logic             grant,
    output logic             irq_req,
    output logic             gdis,
    output logic             push_ctx,
    output logic [VEC_W-1:0] rd_addr,
    output logic             fetch_busy,
    output logic [15:0]      isr_addr,
    output logic             isr_valid
);
    irqc_state_t      st;
    logic [VEC_W-1:0] vec_q;
    logic [7:0]       hi_q;
    logic [7:0]       lo_q;

    // Request and grant are only live while idle.
    always_comb begin
        irq_req = avail && (st == ST_IDLE);
        grant   = irq_req && irq_ack;
    end

    // Sequencer state, vector latch and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            vec_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            push_ctx <= 1'b0;
        end else begin
            push_ctx <= grant;
            case (st)
                ST_IDLE:  if (grant) begin
                              st    <= ST_HI;
                              vec_q <= vec_in;
                          end
                ST_HI:    begin
                              hi_q <= rd_data;
                              st   <= ST_LO;
                          end
                ST_LO:    begin
                              lo_q <= rd_data;
                              st   <= ST_SERVE;
                          end
                default:  if (reti) st <= ST_IDLE;
            endcase
        end
    end

    // Output decode from sequencer state.
    always_comb begin
        gdis       = (st != ST_IDLE);
        fetch_busy = (st == ST_HI) || (st == ST_LO);
        isr_valid  = (st == ST_SERVE);
        rd_addr    = (st == ST_LO) ? vec_q + VEC_W'(1) : vec_q;
        isr_addr   = {hi_q, lo_q};
    end
endmodule

// File: rtl/irqc_top.sv
// Multi-level vectored interrupt controller top: register port,
// pending bank, arbiter and grant/fetch sequencer.
// Assumes NUM_SRC >= PRIO_W and NUM_SRC >= NUM_LVL.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = IRQC_NUM_SRC,
    parameter int NUM_LVL = IRQC_NUM_LVL,
    parameter int NUM_OWN = IRQC_NUM_OWN,
    parameter int PRIO_W  = 8,
    parameter int VEC_W   = 8,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic               irq_ack,
    input  logic               reti,
    input  logic [7:0]         vec_rd_data,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               gdis,
    output logic               push_ctx,
    output logic [VEC_W-1:0]   vec_rd_addr,
    output logic               fetch_busy,
    output logic [15:0]        isr_addr,
    output logic               isr_valid,
    output logic [NUM_SRC-1:0] pend
);
    logic [PRIO_W-1:0]  prio_q;
    logic [NUM_LVL-1:0] lvl_en_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic [SRC_W-1:0]   win_src;
    logic               any;
    logic               grant;

    // Priority code and level enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q   <= '0;
            lvl_en_q <= '1;
        end else if (wr_en) begin
            if (wr_sel == 2'd0) prio_q   <= wr_data[PRIO_W-1:0];
            if (wr_sel == 2'd1) lvl_en_q <= wr_data[NUM_LVL-1:0];
        end
    end

    // Clear mask: software write-one-to-clear plus grant of an owned vector.
    always_comb begin
        clr_mask = (wr_en && wr_sel == 2'd2) ? wr_data : '0;
        if (grant && int'(win_src) < NUM_OWN)
            clr_mask[win_src] = 1'b1;
    end

    irqc_pending #(.N(NUM_SRC)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    irqc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_LVL),
        .NUM_OWN (NUM_OWN),
        .PRIO_W  (PRIO_W),
        .VEC_W   (VEC_W)
    ) arb_i (
        .pend    (pend),
        .lvl_en  (lvl_en_q),
        .prio    (prio_q),
        .any     (any),
        .win_lvl (irq_level),
        .win_src (win_src),
        .win_vec (irq_vector)
    );

    irqc_fetch #(.VEC_W(VEC_W)) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .avail      (any),
        .irq_ack    (irq_ack),
        .reti       (reti),
        .vec_in     (irq_vector),
        .rd_data    (vec_rd_data),
        .grant      (grant),
        .irq_req    (irq_req),
        .gdis       (gdis),
        .push_ctx   (push_ctx),
        .rd_addr    (vec_rd_addr),
        .fetch_busy (fetch_busy),
        .isr_addr   (isr_addr),
        .isr_valid  (isr_valid)
    );
endmodule

// File: rtl/irqc_checker.sv
// Protocol properties for irqc_top, attached by bind.
// Assumes irq_ack and reti are driven synchronously to clk.
module irqc_checker #(
    parameter int NUM_LVL = 7,
    parameter int VEC_W   = 8,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic               irq_ack,
    input logic               reti,
    input logic               gdis,
    input logic               push_ctx,
    input logic               fetch_busy,
    input logic               isr_valid,
    input logic [VEC_W-1:0]   vec_rd_addr,
    input logic [LVL_W-1:0]   irq_level,
    input logic [VEC_W-1:0]   irq_vector,
    input logic [NUM_LVL-1:0] lvl_en
);
    a_r3_enabled_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((lvl_en >> irq_level) & NUM_LVL'(1)) != '0);

    a_r5_vector_even: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[0] == 1'b0 && irq_vector >= VEC_W'(8'hC0)));

    a_r7_grant_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (gdis && push_ctx));

    a_r7_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        push_ctx |=> !push_ctx);

    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_busy && push_ctx) |=> (fetch_busy && vec_rd_addr == $past(vec_rd_addr) + VEC_W'(1)));

    a_r8_valid_after: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_busy && !push_ctx) |=> isr_valid);

    a_r9_no_req_masked: assert property (@(posedge clk) disable iff (!rst_n)
        gdis |-> !irq_req);

    a_r9_hold_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (gdis && !(reti && isr_valid)) |=> gdis);

    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!gdis && !(irq_req && irq_ack)) |=> !push_ctx);
endmodule

bind irqc_top irqc_checker #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_ack     (irq_ack),
    .reti        (reti),
    .gdis        (gdis),
    .push_ctx    (push_ctx),
    .fetch_busy  (fetch_busy),
    .isr_valid   (isr_valid),
    .vec_rd_addr (vec_rd_addr),
    .irq_level   (irq_level),
    .irq_vector  (irq_vector),
    .lvl_en      (lvl_en_q)
);

// File: tb/irqc_top_tb_top.sv
// Self-checking bench for irqc_top: table-driven arbitration checks,
// then directed reset, pending, grant and fetch tests.
module irqc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] src_req = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [16:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic        reti = 1'b0;
    logic [7:0]  vec_rd_data;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;
    logic        gdis;
    logic        push_ctx;
    logic [7:0]  vec_rd_addr;
    logic        fetch_busy;
    logic [15:0] isr_addr;
    logic        isr_valid;
    logic [16:0] pend;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Vector memory model: byte = address xor 0x5A.
    assign vec_rd_data = vec_rd_addr ^ 8'h5A;

    irqc_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack), .reti(reti),
        .vec_rd_data(vec_rd_data), .irq_req(irq_req), .irq_level(irq_level),
        .irq_vector(irq_vector), .gdis(gdis), .push_ctx(push_ctx),
        .vec_rd_addr(vec_rd_addr), .fetch_busy(fetch_busy),
        .isr_addr(isr_addr), .isr_valid(isr_valid), .pend(pend)
    );

    // Entry: {prio[8], en[7], src[17], req[1], level[3], vector[8]}
    localparam logic [43:0] TBL [NTAB] = '{
        {8'd0,   7'h7F, 17'h00210, 1'b1, 3'd2, 8'hC8},
        {8'd3,   7'h7F, 17'h00082, 1'b1, 3'd3, 8'hCE},
        {8'd7,   7'h7F, 17'h04001, 1'b1, 3'd6, 8'hDA},
        {8'h20,  7'h7F, 17'h05000, 1'b1, 3'd5, 8'hD8},
        {8'd0,   7'h7E, 17'h10001, 1'b1, 3'd6, 8'hDA},
        {8'd0,   7'h7F, 17'h01C00, 1'b1, 3'd5, 8'hD4},
        {8'd5,   7'h7F, 17'h08808, 1'b1, 3'd5, 8'hD6},
        {8'd0,   7'h00, 17'h00001, 1'b0, 3'd0, 8'h00},
        {8'd6,   7'h7F, 17'h00024, 1'b1, 3'd1, 8'hC4}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [16:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R11 reset state
        chk("R11 pend", 32'(pend), 0);
        chk("R11 irq_req", 32'(irq_req), 0);
        chk("R11 gdis", 32'(gdis), 0);
        chk("R11 push_ctx", 32'(push_ctx), 0);
        chk("R11 busy/valid", {fetch_busy, isr_valid}, 0);
        rst_n = 1'b1;
        tick();

        // Table walk: R3 R4 R5 R6 arbitration
        for (int i = 0; i < NTAB; i++) begin
            reg_wr(2'd2, '1);
            reg_wr(2'd0, 17'(TBL[i][43:36]));
            reg_wr(2'd1, 17'(TBL[i][35:29]));
            src_req = TBL[i][28:12];
            tick();
            src_req = '0;
            tick();
            chk($sformatf("R3 R4 irq_req row %0d", i), 32'(irq_req), 32'(TBL[i][11]));
            if (TBL[i][11]) begin
                chk($sformatf("R4 R6 level row %0d", i), 32'(irq_level), 32'(TBL[i][10:8]));
                chk($sformatf("R5 vector row %0d", i), 32'(irq_vector), 32'(TBL[i][7:0]));
            end
        end

        // R1 edge-only set
        reg_wr(2'd2, '1);
        reg_wr(2'd0, 17'd0);
        reg_wr(2'd1, 17'h7F);
        src_req = 17'h00001;
        tick();
        chk("R1 set on rise", 32'(pend[0]), 1);
        reg_wr(2'd2, 17'h00001);
        tick();
        chk("R1 held level no reset", 32'(pend[0]), 0);
        src_req = '0; tick();
        src_req = 17'h00001; tick();
        chk("R1 second rise", 32'(pend[0]), 1);
        src_req = '0;
        // R2 zero bits leave flags alone
        reg_wr(2'd2, 17'h00020);
        chk("R2 unaffected flag", 32'(pend), 32'h1);
        reg_wr(2'd2, 17'h00001);
        chk("R2 cleared flag", 32'(pend), 0);

        // Grant and fetch: sources 3 and 14
        src_req = 17'h04008; tick(); src_req = '0; tick();
        chk("R6 winner level", 32'(irq_level), 2);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R7 gdis", 32'(gdis), 1);
        chk("R7 push pulse", 32'(push_ctx), 1);
        chk("R8 first addr", 32'(vec_rd_addr), 32'hC6);
        chk("R8 busy 1", 32'(fetch_busy), 1);
        chk("R9 no req", 32'(irq_req), 0);
        chk("R10 owned cleared", 32'(pend[3]), 0);
        reti = 1'b1; tick(); reti = 1'b0;
        chk("R7 push ends", 32'(push_ctx), 0);
        chk("R8 second addr", 32'(vec_rd_addr), 32'hC7);
        chk("R8 busy 2", 32'(fetch_busy), 1);
        tick();
        chk("R8 isr_valid", 32'(isr_valid), 1);
        chk("R8 isr_addr", 32'(isr_addr), 32'h9C9D);
        chk("R8 busy done", 32'(fetch_busy), 0);
        tick(); tick();
        chk("R9 reti in fetch ignored", 32'(gdis), 1);
        chk("R9 req held off", 32'(irq_req), 0);
        reti = 1'b1; tick(); reti = 1'b0;
        chk("R9 gdis released", 32'(gdis), 0);
        chk("R9 req again", 32'(irq_req), 1);
        chk("R5 shared vector", 32'(irq_vector), 32'hDA);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R10 shared stays", 32'(pend[14]), 1);
        tick(); tick();
        chk("R8 shared isr_addr", 32'(isr_addr), 32'h8081);
        reti = 1'b1; tick(); reti = 1'b0;

        // R12 acknowledge with nothing pending
        reg_wr(2'd2, '1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R12 no grant gdis", 32'(gdis), 0);
        chk("R12 no push", 32'(push_ctx), 0);

        finish_run();
    end
endmodule